// File: doc/BRIEF.md
# Filtered Bandwidth Usage Monitor

This block is one bandwidth usage monitor in a memory-side controller. Each cycle it may see one transfer beat. The beat carries a byte count, a partition identifier, a monitoring group and a security state. Beats that pass the monitor's filters add their bytes to a 31-bit running total. The filters are the security state fixed at elaboration, plus an optional partition match and an optional group match.

Software reaches the monitor through a plain register port with four word addresses: control, filter, live count and capture. It sets up the monitor and reads the results there. A capture copies the live total into the capture register. The event that triggers it is picked from six external event lines, a software capture pulse, or nothing. The copy can also clear the live total.

On overflow the total either wraps or freezes. An overflow sets a sticky status bit and can drive an interrupt line. The count and capture registers can be read as raw bytes or shifted right by a fixed scale.

Top module: `bwmon_top`

## Requirements
- R1: Control word layout:
  - Bit 31: enable. Bits 30:28: capture select. Bit 27: capture-clear. Bit 26: overflow status. Bit 25: interrupt enable. Bit 24: freeze.
  - Bit 19: scaling. Bit 17: group match. Bit 16: partition match.
  - Bits 7:0 are a read-only type code that always reads 0x42.
  - Bits 23:20 read zero and ignore writes, as do all other unlisted bits.
  - After reset the control word reads 0x00000042, and the filter, count and capture registers read 0.
- R2: While the enable bit is 0, transfers add nothing to the count and capture events have no effect.
- R3: When enabled, a beat with `xfer_valid` high and `xfer_secure` equal to the parameter `MON_SECURE` adds `xfer_bytes` (0 to 255) to the count. Beats of the other security state add nothing.
- R4: The filter register holds the partition value in bits [PARTID_W-1:0] and the group value in bits [16+PMG_W-1:16]. With partition match set, only beats whose partition equals the filter value are counted. With group match set, only beats whose group equals the filter value are counted. A match bit at 0 ignores that attribute.
- R5: Capture select 0 never captures. Select k (1 to 6) captures on a high cycle of `capt_ext[k-1]`, but only if bit k-1 of `EXT_IMPL` is 1. Select 7 captures on `capt_sw` only when `capt_sw_secure` equals `MON_SECURE`. Unimplemented sources never capture.
- R6: A capture copies the count, as it stood before that cycle's update, into the capture register. With capture-clear set, the count restarts from zero in the same cycle, and a beat counted in that cycle lands on the cleared value.
- R7: With freeze 0, a sum beyond 2^31-1 wraps modulo 2^31. Any overflow sets the status bit, which stays 1 until software writes it 0.
- R8: With freeze 1, an overflow leaves the wrapped post-increment value, so an increment of 1 from 2^31-1 gives 0. The count then holds until software writes the count register or writes the status bit to 0.
- R9: With the interrupt enable set, `ovf_irq` goes high two cycles after the overflowing beat. It stays high while the status bit is set, and falls once the status is written 0.
- R10: With scaling set, the count and capture registers read as the byte total shifted right by `SCALE`. With scaling clear they read as the raw total.
- R11: Addresses 0 to 3 select control, filter, count and capture. `reg_rdata` gives the addressed register one cycle after the address. A count write loads the raw total from bits 30:0. Writes to the capture register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_valid | input | 1 | Transfer beat present |
| xfer_bytes | input | BYTE_W | Bytes moved by the beat |
| xfer_partid | input | PARTID_W | Partition identifier of the beat |
| xfer_pmg | input | PMG_W | Monitoring group of the beat |
| xfer_secure | input | 1 | Security state of the beat |
| capt_ext | input | 6 | External capture event lines 1 to 6 |
| capt_sw | input | 1 | Software capture pulse |
| capt_sw_secure | input | 1 | Security state the software capture targets |
| reg_addr | input | 2 | Register word address |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ovf_irq | output | 1 | Overflow interrupt |

## Verification
Some properties are checked on every cycle:
- The count holds while the monitor is disabled or frozen.
- A capture copies the previous count.
- The status bit stays set until software clears it.
- An overflow with the interrupt enabled raises the interrupt two cycles later.
- The type code is returned on every control read.

Only the bench scenarios can show the rest:
- the exact byte totals produced by each filter combination;
- which capture select and source pairs really fire, including the unimplemented sources;
- where the wrapped or frozen value lands;
- the scaled readout.

// File: rtl/bwmon_pkg.sv
package bwmon_pkg;
  localparam logic [7:0] MON_TYPE   = 8'h42;
  localparam int         EXT_EVENTS = 6;

  typedef enum logic [1:0] {
    RA_CTL = 2'd0,
    RA_FLT = 2'd1,
    RA_CNT = 2'd2,
    RA_CAP = 2'd3
  } reg_addr_e;

  // control bit positions (software-visible layout)
  localparam int B_EN    = 31;
  localparam int B_CSEL  = 28;
  localparam int B_CRST  = 27;
  localparam int B_OSTS  = 26;
  localparam int B_IRQ   = 25;
  localparam int B_FRZ   = 24;
  localparam int B_SCL   = 19;
  localparam int B_MPMG  = 17;
  localparam int B_MPART = 16;

  typedef struct packed {
    logic       en;
    logic [2:0] capt_sel;
    logic       capt_rst;
    logic       irq_en;
    logic       frz;
    logic       scale_en;
    logic       match_pmg;
    logic       match_part;
  } ctl_t;
endpackage

// File: rtl/bwmon_filter.sv
module bwmon_filter #(
  parameter int PARTID_W   = 8,
  parameter int PMG_W      = 4,
  parameter int BYTE_W     = 8,
  parameter bit MON_SECURE = 1'b0
) (
  input  logic                en,
  input  logic                xfer_valid,
  input  logic [BYTE_W-1:0]   xfer_bytes,
  input  logic [PARTID_W-1:0] xfer_partid,
  input  logic [PMG_W-1:0]    xfer_pmg,
  input  logic                xfer_secure,
  input  logic                match_part,
  input  logic                match_pmg,
  input  logic [PARTID_W-1:0] flt_partid,
  input  logic [PMG_W-1:0]    flt_pmg,
  output logic [BYTE_W-1:0]   inc
);
  logic pass;

  always_comb begin
    pass = en && xfer_valid && (xfer_secure == MON_SECURE)
        && (!match_part || (xfer_partid == flt_partid))
        && (!match_pmg  || (xfer_pmg == flt_pmg));
    inc  = pass ? xfer_bytes : '0;
  end
endmodule

// File: rtl/bwmon_capsel.sv
module bwmon_capsel
  import bwmon_pkg::*;
#(
  parameter logic [EXT_EVENTS-1:0] EXT_IMPL   = 6'b001011,
  parameter bit                    SW_IMPL    = 1'b1,
  parameter bit                    MON_SECURE = 1'b0
) (
  input  logic                  en,
  input  logic [2:0]            sel,
  input  logic [EXT_EVENTS-1:0] ext_evt,
  input  logic                  sw_evt,
  input  logic                  sw_secure,
  output logic                  fire
);
  logic [7:0] hit;

  assign hit[0] = 1'b0;

  for (genvar i = 1; i <= EXT_EVENTS; i++) begin : g_ext
    if (EXT_IMPL[i-1]) begin : g_on
      assign hit[i] = ext_evt[i-1];
    end else begin : g_off
      assign hit[i] = 1'b0;
    end
  end

  if (SW_IMPL) begin : g_sw
    assign hit[7] = sw_evt && (sw_secure == MON_SECURE);
  end else begin : g_nosw
    assign hit[7] = 1'b0;
  end

  assign fire = en && hit[sel];
endmodule

// File: rtl/bwmon_accum.sv
module bwmon_accum #(
  parameter int CNT_W = 31,
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [INC_W-1:0] inc,
  input  logic             fire,
  input  logic             capt_rst,
  input  logic             frz_en,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             thaw,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capt,
  output logic             ovf
);
  logic [CNT_W-1:0] count_q, capt_q, base;
  logic [CNT_W:0]   sum;
  logic             frozen_q;

  always_comb begin
    base = (fire && capt_rst) ? '0 : count_q;
    sum  = {1'b0, base} + {{(CNT_W+1-INC_W){1'b0}}, inc};
    ovf  = sum[CNT_W] && !frozen_q && !cnt_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q  <= '0;
      capt_q   <= '0;
      frozen_q <= 1'b0;
    end else begin
      if (fire) capt_q <= count_q;
      if (cnt_wr) begin
        count_q  <= cnt_wdata;
        frozen_q <= 1'b0;
      end else begin
        if (!frozen_q)                count_q <= sum[CNT_W-1:0];
        else if (fire && capt_rst)    count_q <= '0;
        if (ovf && frz_en)            frozen_q <= 1'b1;
        else if (thaw)                frozen_q <= 1'b0;
      end
    end
  end

  assign count = count_q;
  assign capt  = capt_q;

  // R8: a frozen count holds unless software or a clearing capture touches it
  a_r8_frozen_hold: assert property (@(posedge clk) disable iff (rst)
    (frozen_q && !cnt_wr && !(fire && capt_rst)) |=> $stable(count_q));

  // R6: capture takes the count seen in the capture cycle
  a_r6_capt_copy: assert property (@(posedge clk) disable iff (rst)
    fire |=> (capt_q == $past(count_q)));
endmodule

// File: rtl/bwmon_top.sv
module bwmon_top
  import bwmon_pkg::*;
#(
  parameter int                    PARTID_W     = 8,
  parameter int                    PMG_W        = 4,
  parameter int                    BYTE_W       = 8,
  parameter int                    CNT_W        = 31,
  parameter logic [4:0]            SCALE        = 5'd3,
  parameter logic [EXT_EVENTS-1:0] EXT_IMPL     = 6'b001011,
  parameter bit                    SW_CAPT_IMPL = 1'b1,
  parameter bit                    MON_SECURE   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  xfer_valid,
  input  logic [BYTE_W-1:0]     xfer_bytes,
  input  logic [PARTID_W-1:0]   xfer_partid,
  input  logic [PMG_W-1:0]      xfer_pmg,
  input  logic                  xfer_secure,
  input  logic [EXT_EVENTS-1:0] capt_ext,
  input  logic                  capt_sw,
  input  logic                  capt_sw_secure,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wen,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  ovf_irq
);
  localparam int PAD_W = 32 - CNT_W;

  ctl_t                ctl_q;
  logic                ovf_sts_q, irq_q;
  logic [PARTID_W-1:0] flt_partid_q;
  logic [PMG_W-1:0]    flt_pmg_q;
  logic [31:0]         rdata_q, ctl_word, flt_word;
  logic                ctl_wr, flt_wr, cnt_wr, thaw, fire, ovf;
  logic [BYTE_W-1:0]   inc;
  logic [CNT_W-1:0]    count, capt;

  assign ctl_wr = reg_wen && (reg_addr == RA_CTL);
  assign flt_wr = reg_wen && (reg_addr == RA_FLT);
  assign cnt_wr = reg_wen && (reg_addr == RA_CNT);
  assign thaw   = ctl_wr && !reg_wdata[B_OSTS];

  bwmon_filter #(
    .PARTID_W(PARTID_W), .PMG_W(PMG_W), .BYTE_W(BYTE_W), .MON_SECURE(MON_SECURE)
  ) u_filter (
    .en(ctl_q.en), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
    .xfer_partid(xfer_partid), .xfer_pmg(xfer_pmg), .xfer_secure(xfer_secure),
    .match_part(ctl_q.match_part), .match_pmg(ctl_q.match_pmg),
    .flt_partid(flt_partid_q), .flt_pmg(flt_pmg_q), .inc(inc)
  );

  bwmon_capsel #(
    .EXT_IMPL(EXT_IMPL), .SW_IMPL(SW_CAPT_IMPL), .MON_SECURE(MON_SECURE)
  ) u_capsel (
    .en(ctl_q.en), .sel(ctl_q.capt_sel), .ext_evt(capt_ext),
    .sw_evt(capt_sw), .sw_secure(capt_sw_secure), .fire(fire)
  );

  bwmon_accum #(.CNT_W(CNT_W), .INC_W(BYTE_W)) u_accum (
    .clk(clk), .rst(rst), .inc(inc), .fire(fire), .capt_rst(ctl_q.capt_rst),
    .frz_en(ctl_q.frz), .cnt_wr(cnt_wr), .cnt_wdata(reg_wdata[CNT_W-1:0]),
    .thaw(thaw), .count(count), .capt(capt), .ovf(ovf)
  );

  function automatic logic [31:0] view(input logic [CNT_W-1:0] raw, input logic sc);
    logic [CNT_W-1:0] v;
    v = sc ? (raw >> SCALE) : raw;
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_comb begin
    ctl_word                = '0;
    ctl_word[B_EN]          = ctl_q.en;
    ctl_word[B_CSEL +: 3]   = ctl_q.capt_sel;
    ctl_word[B_CRST]        = ctl_q.capt_rst;
    ctl_word[B_OSTS]        = ovf_sts_q;
    ctl_word[B_IRQ]         = ctl_q.irq_en;
    ctl_word[B_FRZ]         = ctl_q.frz;
    ctl_word[B_SCL]         = ctl_q.scale_en;
    ctl_word[B_MPMG]        = ctl_q.match_pmg;
    ctl_word[B_MPART]       = ctl_q.match_part;
    ctl_word[7:0]           = MON_TYPE;
    flt_word                = '0;
    flt_word[PARTID_W-1:0]  = flt_partid_q;
    flt_word[16 +: PMG_W]   = flt_pmg_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      ovf_sts_q    <= 1'b0;
      irq_q        <= 1'b0;
      flt_partid_q <= '0;
      flt_pmg_q    <= '0;
      rdata_q      <= '0;
    end else begin
      if (ctl_wr) begin
        ctl_q.en         <= reg_wdata[B_EN];
        ctl_q.capt_sel   <= reg_wdata[B_CSEL +: 3];
        ctl_q.capt_rst   <= reg_wdata[B_CRST];
        ctl_q.irq_en     <= reg_wdata[B_IRQ];
        ctl_q.frz        <= reg_wdata[B_FRZ];
        ctl_q.scale_en   <= reg_wdata[B_SCL];
        ctl_q.match_pmg  <= reg_wdata[B_MPMG];
        ctl_q.match_part <= reg_wdata[B_MPART];
      end
      if (ovf)         ovf_sts_q <= 1'b1;
      else if (ctl_wr) ovf_sts_q <= reg_wdata[B_OSTS];
      if (flt_wr) begin
        flt_partid_q <= reg_wdata[PARTID_W-1:0];
        flt_pmg_q    <= reg_wdata[16 +: PMG_W];
      end
      irq_q <= ovf_sts_q && ctl_q.irq_en;
      case (reg_addr)
        RA_CTL:  rdata_q <= ctl_word;
        RA_FLT:  rdata_q <= flt_word;
        RA_CNT:  rdata_q <= view(count, ctl_q.scale_en);
        default: rdata_q <= view(capt, ctl_q.scale_en);
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign ovf_irq   = irq_q;

  // R2: disabled monitor keeps its count unless software writes it
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q.en && !cnt_wr) |=> $stable(count));

  // R7: status is sticky until software writes 0
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_sts_q && !thaw) |=> ovf_sts_q);

  // R9: enabled overflow reaches the interrupt two cycles later
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (rst)
    (ovf && ctl_q.irq_en && !ctl_wr) |=> ##1 ovf_irq);

  // R3: no increment without a beat
  a_r3_inc_needs_beat: assert property (@(posedge clk) disable iff (rst)
    (inc != '0) |-> xfer_valid);

  // R1: control reads always carry the type code
  a_r1_type_code: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == RA_CTL) |=> (reg_rdata[7:0] == MON_TYPE));
endmodule

// File: tb/test_bwmon_top.sv
module test_bwmon_top;
  localparam logic [5:0]  IMPL = 6'b001011;
  localparam logic [31:0] MAXC = 32'h7FFF_FFFF;
  localparam logic [31:0] EN   = 32'h8000_0000;
  localparam logic [31:0] CRST = 32'h0800_0000;
  localparam logic [31:0] OSTS = 32'h0400_0000;
  localparam logic [31:0] IRQE = 32'h0200_0000;
  localparam logic [31:0] FRZ  = 32'h0100_0000;
  localparam logic [31:0] SCL  = 32'h0008_0000;

  logic        clk = 1'b0, rst = 1'b1;
  logic        xfer_valid = 1'b0, xfer_secure = 1'b0;
  logic [7:0]  xfer_bytes = '0, xfer_partid = '0;
  logic [3:0]  xfer_pmg = '0;
  logic [5:0]  capt_ext = '0;
  logic        capt_sw = 1'b0, capt_sw_secure = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ovf_irq;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  bwmon_top i_bwmon_top (
    .clk(clk), .rst(rst), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
    .xfer_partid(xfer_partid), .xfer_pmg(xfer_pmg), .xfer_secure(xfer_secure),
    .capt_ext(capt_ext), .capt_sw(capt_sw), .capt_sw_secure(capt_sw_secure),
    .reg_addr(reg_addr), .reg_wen(reg_wen), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic beat(input logic [7:0] b, input logic [7:0] p, input logic [3:0] g,
                      input logic s);
    @(negedge clk);
    xfer_valid = 1'b1; xfer_bytes = b; xfer_partid = p; xfer_pmg = g; xfer_secure = s;
    @(negedge clk); xfer_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, expc, capexp;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); chk("R1 reset ctl", v, 32'h0000_0042);
    rd(2'd1, v); chk("R1 reset flt", v, 0);
    rd(2'd2, v); chk("R1 reset cnt", v, 0);
    rd(2'd3, v); chk("R1 reset cap", v, 0);
    chk("R1 reset irq", {31'b0, ovf_irq}, 0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R1 ctl mask", v, 32'hFF0B_0042);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, v); chk("R1 ctl clear", v, 32'h0000_0042);

    // R2 disabled: no count, no capture
    wr(2'd0, 32'h1000_0000);
    wr(2'd2, 32'd77);
    beat(8'd100, 8'd0, 4'd0, 1'b0);
    @(negedge clk); capt_ext = 6'b000001; @(negedge clk); capt_ext = '0;
    rd(2'd2, v); chk("R2 disabled count", v, 77);
    rd(2'd3, v); chk("R2 disabled capture", v, 0);

    // R3 security state and byte range
    wr(2'd0, EN); wr(2'd2, 0);
    beat(8'd255, 8'd0, 4'd0, 1'b0);
    beat(8'd0,   8'd0, 4'd0, 1'b0);
    beat(8'd90,  8'd0, 4'd0, 1'b1);
    rd(2'd2, v); chk("R3 secure filter and bytes", v, 255);

    // R4 filter sweep
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R4 filter readback", v, 32'h000F_00FF);
    wr(2'd1, 32'h0001_0002);
    for (int mp = 0; mp < 2; mp++) begin
      for (int mg = 0; mg < 2; mg++) begin
        wr(2'd0, EN | (32'(mg) << 17) | (32'(mp) << 16));
        wr(2'd2, 0);
        expc = 0;
        for (int p = 0; p < 4; p++) begin
          for (int g = 0; g < 4; g++) begin
            beat(8'(1 + p*4 + g), 8'(p), 4'(g), 1'b0);
            if ((mp == 0 || p == 2) && (mg == 0 || g == 1)) expc += 32'(1 + p*4 + g);
          end
        end
        rd(2'd2, v); chk("R4 match sweep", v, expc);
      end
    end

    // R5 capture source sweep
    capexp = 0;
    rd(2'd3, capexp);
    for (int sel = 0; sel < 8; sel++) begin
      for (int src = 1; src < 8; src++) begin
        wr(2'd0, EN | (32'(sel) << 28));
        wr(2'd2, 32'(1000 + sel*8 + src));
        @(negedge clk);
        if (src == 7) capt_sw = 1'b1; else capt_ext = 6'(1) << (src - 1);
        @(negedge clk); capt_sw = 1'b0; capt_ext = '0;
        if (sel == src && (src == 7 || IMPL[src-1])) capexp = 32'(1000 + sel*8 + src);
        rd(2'd3, v); chk("R5 capture source", v, capexp);
      end
    end
    wr(2'd2, 32'd4242);
    @(negedge clk); capt_sw = 1'b1; capt_sw_secure = 1'b1;
    @(negedge clk); capt_sw = 1'b0; capt_sw_secure = 1'b0;
    rd(2'd3, v); chk("R5 sw capture other state", v, capexp);

    // R6 capture with clear plus same-cycle beat
    wr(2'd0, EN | CRST | (32'd1 << 28));
    wr(2'd2, 32'd500);
    @(negedge clk);
    capt_ext = 6'b000001; xfer_valid = 1'b1; xfer_bytes = 8'd20; xfer_partid = 0;
    xfer_pmg = 0; xfer_secure = 1'b0;
    @(negedge clk); capt_ext = '0; xfer_valid = 1'b0;
    rd(2'd3, v); chk("R6 capture copy", v, 500);
    rd(2'd2, v); chk("R6 cleared plus beat", v, 20);
    wr(2'd0, EN | (32'd1 << 28));
    wr(2'd2, 32'd600);
    @(negedge clk); capt_ext = 6'b000001; @(negedge clk); capt_ext = '0;
    rd(2'd2, v); chk("R6 no clear keeps count", v, 600);

    // R7 wrap and sticky status
    wr(2'd0, EN);
    wr(2'd2, MAXC - 9);
    beat(8'd15, 8'd0, 4'd0, 1'b0);
    rd(2'd2, v); chk("R7 wrapped", v, 5);
    beat(8'd3, 8'd0, 4'd0, 1'b0);
    rd(2'd0, v); chk("R7 status sticky", v & OSTS, OSTS);
    wr(2'd0, EN);
    rd(2'd0, v); chk("R7 status cleared", v & OSTS, 0);

    // R8 freeze
    wr(2'd0, EN | FRZ);
    wr(2'd2, MAXC);
    beat(8'd1, 8'd0, 4'd0, 1'b0);
    beat(8'd50, 8'd0, 4'd0, 1'b0);
    rd(2'd2, v); chk("R8 frozen at zero", v, 0);
    wr(2'd2, MAXC - 2);
    beat(8'd10, 8'd0, 4'd0, 1'b0);
    beat(8'd5, 8'd0, 4'd0, 1'b0);
    rd(2'd2, v); chk("R8 frozen wrapped value", v, 7);
    wr(2'd0, EN | FRZ);
    beat(8'd5, 8'd0, 4'd0, 1'b0);
    rd(2'd2, v); chk("R8 thaw on status clear", v, 12);

    // R9 interrupt
    wr(2'd0, EN);
    wr(2'd2, MAXC);
    beat(8'd2, 8'd0, 4'd0, 1'b0);
    @(negedge clk);
    chk("R9 irq disabled", {31'b0, ovf_irq}, 0);
    wr(2'd0, EN | IRQE);
    wr(2'd2, MAXC);
    beat(8'd2, 8'd0, 4'd0, 1'b0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, ovf_irq}, 1);
    wr(2'd0, EN | IRQE);
    @(negedge clk);
    chk("R9 irq falls", {31'b0, ovf_irq}, 0);

    // R10 scaling
    wr(2'd0, EN | SCL | (32'd7 << 28));
    wr(2'd2, 32'd1000);
    rd(2'd2, v); chk("R10 scaled count", v, 1000 >> 3);
    @(negedge clk); capt_sw = 1'b1; @(negedge clk); capt_sw = 1'b0;
    rd(2'd3, v); chk("R10 scaled capture", v, 1000 >> 3);
    wr(2'd0, EN);
    rd(2'd3, v); chk("R10 raw capture", v, 1000);

    // R11 capture register ignores writes
    wr(2'd3, 32'h0000_1234);
    rd(2'd3, v); chk("R11 capture write ignored", v, 1000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule